// File: doc/BRIEF.md
# Byte-Register SPI Flash Command Engine

This block is a SPI master that runs a single flash command set up through a byte-wide register port. Software writes a command byte and the transmit and receive byte counts. It loads the outgoing payload into an eight-entry FIFO through a data port and then requests execution. The engine drops chip select and sends the command byte, which never passes through the FIFO. It then sends the payload bytes from the FIFO and clocks in the requested number of reply bytes, which it stores in the same FIFO after the payload.

When the command is done, software clears the FIFO pointer and reads the FIFO back through the data port. It discards the payload entries and then reads the reply bytes. When no payload is sent, the byte clocked in while the command byte goes out counts as the first reply byte. That byte is a dummy, so software asks for one more reply byte than it needs. The serial clock is the system clock divided by a fixed even ratio, in SPI mode 0 with the most significant bit first.

Top module: `spi_cmd_engine`

## Requirements
- R1: Offset 0x00 holds the command byte. It is read back unchanged and is always the first byte sent on the serial line after chip select falls, most significant bit first. It is never written into the FIFO.
- R2: A write to offset 0x01 sets the transmit count from bits [3:0] and the receive count from bits [7:4]. A read of 0x01 returns the low four bits of each count in the same positions.
- R3: Offset 0x1E selects an extended count and offset 0x1F reads or writes it as a full byte. Index 5 is the transmit count and index 6 is the receive count. A read of 0x1F at any other index returns 0.
- R4: Writing 1 to bit 0 of offset 0x02 starts a command. Bit 0 of 0x02 and bit 7 of 0x03 then read 1 until the frame ends, and both read 0 afterwards.
- R5: A read or write of offset 0x0C reaches the FIFO entry at the current pointer, and the pointer then steps by one, modulo 8. Bits [2:0] of offset 0x0D return the pointer, and bits [7:3] read 0.
- R6: Writing 1 to bit 4 of offset 0x02 sets the FIFO pointer to 0.
- R7: The serial clock runs at the system clock divided by CLK_DIV and rests low, and it never pulses while chip select is high. Chip select falls CLK_DIV cycles before the first bit period starts, so the first rising edge comes CLK_DIV*3/2 cycles after the fall. Chip select rises CLK_DIV cycles after the last falling edge. The master changes its data output on falling edges and samples the slave's data on rising edges, with exactly 8 rising edges per byte.
- R8: With a transmit count T > 0 and a receive count N, a frame is 1+T+N bytes long. FIFO entries 0..T-1 are sent after the command byte, and 0x00 is sent during the N receive bytes. The k-th received byte is stored at entry (T+k) mod 8.
- R9: With a transmit count of 0 and a receive count N, a frame is max(1,N) bytes long. The byte clocked in during the command byte goes to entry 0 as the dummy, and the following N-1 received bytes go to entries 1..N-1.
- R10: While a command runs, writes to offsets 0x00, 0x01, 0x02, 0x0C, 0x1E and 0x1F are ignored, and reads of 0x0C do not move the pointer.
- R11: When the transmit and receive counts together exceed 8, received bytes wrap around modulo 8 and overwrite earlier entries, so the last write to an entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register offset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regRdEn | input | 1 | Register read strobe; advances the FIFO pointer for offset 0x0C |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, valid in the same cycle |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock, mode 0 |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
Most faults in the shift sequencing appear on the serial pins within one frame. A slot counter or bit index that is off by one adds or drops rising edges, or moves the first edge relative to the chip select fall. A bad capture index or a bad transmit index only shows when the FIFO is read back after the frame. That readback is a full eight-entry sweep, so a misplaced byte or a broken wrap is found within one command. A gate that fails to hold off writes while busy shows up when the opcode, the counts or the pointer are read back after the frame.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  localparam int COUNT_W    = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int PTR_W      = $clog2(FIFO_DEPTH);
  localparam int BIT_W      = $clog2(DATA_W);

  // Register offsets; software depends on these positions.
  localparam logic [ADDR_W-1:0] OFS_OPCODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNTS = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h03;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PTR    = 5'h0D;
  localparam logic [ADDR_W-1:0] OFS_XIDX   = 5'h1E;
  localparam logic [ADDR_W-1:0] OFS_XDATA  = 5'h1F;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_PCLR_BIT = 4;
  localparam int STAT_BUSY_BIT = 7;

  localparam logic [DATA_W-1:0] XIDX_TX = 8'd5;
  localparam logic [DATA_W-1:0] XIDX_RX = 8'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             hostWr;
    logic             hostRd;
    logic             ptrClr;
    logic             loadOp;
    logic             loadFifo;
    logic             loadZero;
    logic             shiftOut;
    logic             sampleIn;
    logic             capture;
    logic [PTR_W-1:0] txIdx;
    logic [PTR_W-1:0] capIdx;
  } dpStrobe_t;
endpackage

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] opcode,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] fifoRdData,
  output logic [PTR_W-1:0]  fifoPtr
);
  logic [FIFO_DEPTH-1:0][DATA_W-1:0] memView;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  // One register per FIFO entry; capture and host writes never overlap
  for (genvar e = 0; e < FIFO_DEPTH; e++) begin : g_entry
    logic [DATA_W-1:0] entryQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryQ <= '0;
      end else if (strobe.capture && strobe.capIdx == PTR_W'(e)) begin
        entryQ <= rxShift;
      end else if (strobe.hostWr && fifoPtr == PTR_W'(e)) begin
        entryQ <= wrData;
      end
    end
    assign memView[e] = entryQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoPtr <= '0;
    end else if (strobe.ptrClr) begin
      fifoPtr <= '0;
    end else if (strobe.hostWr || strobe.hostRd) begin
      fifoPtr <= fifoPtr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.loadOp) begin
      txShift <= opcode;
    end else if (strobe.loadFifo) begin
      txShift <= memView[strobe.txIdx];
    end else if (strobe.loadZero) begin
      txShift <= '0;
    end else if (strobe.shiftOut) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strobe.sampleIn) begin
      rxShift <= {rxShift[DATA_W-2:0], miso};
    end
  end

  assign mosi       = txShift[DATA_W-1];
  assign fifoRdData = memView[fifoPtr];
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic [PTR_W-1:0]  fifoPtr,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] opcode,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              spiCsN,
  output logic              spiSclk
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int CNT_W  = $clog2(CLK_DIV);
  localparam int SLOT_W = COUNT_W + 1;

  phase_t             phase;
  logic [CNT_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitIdx;
  logic [SLOT_W-1:0]  slot;
  logic [PTR_W-1:0]   txIdx;
  logic [PTR_W-1:0]   capIdx;
  logic [COUNT_W-1:0] txCnt;
  logic [COUNT_W-1:0] rxCnt;
  logic [DATA_W-1:0]  xIdx;

  logic wrOk, wrOpcode, wrCounts, wrCtrl, wrXidx, wrXdata;
  logic startReq, divEnd, byteDone, lastByte, capHit, nextIsTx;
  logic [SLOT_W-1:0] lastSlot, firstCap;

  assign busy     = (phase != ST_IDLE);
  assign wrOk     = regWrEn && !busy;
  assign wrOpcode = wrOk && regAddr == OFS_OPCODE;
  assign wrCounts = wrOk && regAddr == OFS_COUNTS;
  assign wrCtrl   = wrOk && regAddr == OFS_CTRL;
  assign wrXidx   = wrOk && regAddr == OFS_XIDX;
  assign wrXdata  = wrOk && regAddr == OFS_XDATA;
  assign startReq = wrCtrl && regWrData[CTRL_RUN_BIT];

  // Frame geometry, from counts that stay frozen while busy
  always_comb begin
    if (txCnt == '0) begin
      lastSlot = (rxCnt == '0) ? '0 : SLOT_W'(rxCnt) - SLOT_W'(1);
      firstCap = '0;
    end else begin
      lastSlot = SLOT_W'(txCnt) + SLOT_W'(rxCnt);
      firstCap = SLOT_W'(txCnt) + SLOT_W'(1);
    end
  end

  assign divEnd   = (divCnt == CNT_W'(CLK_DIV - 1));
  assign byteDone = (bitIdx == BIT_W'(DATA_W - 1));
  assign lastByte = (slot == lastSlot);
  assign capHit   = (rxCnt != '0) && (slot >= firstCap);
  assign nextIsTx = (slot < SLOT_W'(txCnt));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcode <= '0;
      txCnt  <= '0;
      rxCnt  <= '0;
      xIdx   <= '0;
    end else begin
      if (wrOpcode) opcode <= regWrData;
      if (wrXidx)   xIdx   <= regWrData;
      if (wrCounts) begin
        txCnt <= COUNT_W'(regWrData[3:0]);
        rxCnt <= COUNT_W'(regWrData[7:4]);
      end else if (wrXdata && xIdx == XIDX_TX) begin
        txCnt <= COUNT_W'(regWrData);
      end else if (wrXdata && xIdx == XIDX_RX) begin
        rxCnt <= COUNT_W'(regWrData);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      slot   <= '0;
      txIdx  <= '0;
      capIdx <= '0;
    end else begin
      case (phase)
        ST_IDLE: begin
          if (startReq) begin
            phase  <= ST_LEAD;
            divCnt <= '0;
            bitIdx <= '0;
            slot   <= '0;
            txIdx  <= '0;
            capIdx <= PTR_W'(txCnt);
          end
        end
        ST_LEAD: begin
          if (divEnd) begin
            phase  <= ST_SHIFT;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          divCnt <= divEnd ? '0 : divCnt + CNT_W'(1);
          if (divEnd) begin
            bitIdx <= bitIdx + BIT_W'(1);
            if (byteDone) begin
              if (capHit) capIdx <= capIdx + PTR_W'(1);
              if (lastByte) begin
                phase <= ST_TRAIL;
              end else begin
                slot <= slot + SLOT_W'(1);
                if (nextIsTx) txIdx <= txIdx + PTR_W'(1);
              end
            end
          end
        end
        ST_TRAIL: begin
          if (divEnd) begin
            phase  <= ST_IDLE;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + CNT_W'(1);
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  logic shifting, byteEdge, moreBytes;
  assign shifting  = (phase == ST_SHIFT);
  assign byteEdge  = shifting && divEnd && byteDone;
  assign moreBytes = byteEdge && !lastByte;

  always_comb begin
    strobe          = '0;
    strobe.hostWr   = wrOk && regAddr == OFS_DATA;
    strobe.hostRd   = regRdEn && !busy && regAddr == OFS_DATA;
    strobe.ptrClr   = wrCtrl && regWrData[CTRL_PCLR_BIT];
    strobe.loadOp   = startReq;
    strobe.loadFifo = moreBytes && nextIsTx;
    strobe.loadZero = moreBytes && !nextIsTx;
    strobe.shiftOut = shifting && divEnd && !byteDone;
    strobe.sampleIn = shifting && divCnt == CNT_W'(HALF - 1);
    strobe.capture  = byteEdge && capHit;
    strobe.txIdx    = txIdx;
    strobe.capIdx   = capIdx;
  end

  assign spiCsN  = (phase == ST_IDLE);
  assign spiSclk = shifting && (divCnt >= CNT_W'(HALF));

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_OPCODE: regRdData = opcode;
      OFS_COUNTS: regRdData = {rxCnt[3:0], txCnt[3:0]};
      OFS_CTRL:   regRdData[CTRL_RUN_BIT]  = busy;
      OFS_STAT:   regRdData[STAT_BUSY_BIT] = busy;
      OFS_DATA:   regRdData = fifoRdData;
      OFS_PTR:    regRdData = DATA_W'(fifoPtr);
      OFS_XIDX:   regRdData = xIdx;
      OFS_XDATA: begin
        if (xIdx == XIDX_TX)      regRdData = DATA_W'(txCnt);
        else if (xIdx == XIDX_RX) regRdData = DATA_W'(rxCnt);
      end
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] opcode;
  logic [DATA_W-1:0] fifoRdData;
  logic [PTR_W-1:0]  fifoPtr;
  logic              busy;

  spi_eng_ctrl #(.CLK_DIV(CLK_DIV)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regWrData  (regWrData),
    .fifoRdData (fifoRdData),
    .fifoPtr    (fifoPtr),
    .regRdData  (regRdData),
    .opcode     (opcode),
    .strobe     (strobe),
    .busy       (busy),
    .spiCsN     (spiCsN),
    .spiSclk    (spiSclk)
  );

  spi_eng_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (regWrData),
    .opcode     (opcode),
    .miso       (spiMiso),
    .mosi       (spiMosi),
    .fifoRdData (fifoRdData),
    .fifoPtr    (fifoPtr)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
  import spi_eng_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              spiCsN,
  input logic              spiSclk,
  input logic              busy,
  input logic [PTR_W-1:0]  fifoPtr
);
  localparam logic [DATA_W-1:0] RUN_MASK  = DATA_W'(1) << CTRL_RUN_BIT;
  localparam logic [DATA_W-1:0] PCLR_MASK = DATA_W'(1) << CTRL_PCLR_BIT;

  // R7: serial clock rests low while deselected
  a_r7_sclk_quiet: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  // R4: accepted start makes the engine busy next cycle
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !busy && regAddr == OFS_CTRL && (regWrData & RUN_MASK) != '0) |=> busy);

  // R6: pointer clear lands in one cycle
  a_r6_ptr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !busy && regAddr == OFS_CTRL && (regWrData & PCLR_MASK) != '0) |=> fifoPtr == '0);

  // R5: data port write steps the pointer modulo depth
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !busy && regAddr == OFS_DATA) |=> fifoPtr == PTR_W'($past(fifoPtr) + PTR_W'(1)));

  // R10: pointer frozen against host writes while busy
  a_r10_ptr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && (regAddr == OFS_DATA || regAddr == OFS_CTRL)) |=> $stable(fifoPtr));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk chk_i (.*);

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       spiCsN, spiSclk, spiMosi;
  logic       spiMiso = 1'b0;

  int checks = 0;
  int errors = 0;

  spi_cmd_engine #(.CLK_DIV(DIV)) dut_i (.*);

  always #5 clk = ~clk;

  // ---------------- SPI slave model ----------------
  int   riseCnt = 0;
  logic mosiBits [0:1023];
  time  tCsFall, tFirstRise, tLastFall, tCsRise;

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 29 + 8'h5A) & 8'hFF);
  endfunction
  function automatic logic patBit(input int n);
    logic [7:0] b;
    b = pat(n / 8);
    return b[7 - (n % 8)];
  endfunction
  function automatic logic [7:0] payload(input logic [7:0] op, input int i);
    return op ^ 8'((i * 17 + 3) & 8'hFF);
  endfunction

  always @(posedge spiSclk) begin
    if (riseCnt == 0) tFirstRise = $time;
    if (riseCnt < 1024) mosiBits[riseCnt] = spiMosi;
    riseCnt = riseCnt + 1;
  end
  always @(negedge spiSclk or negedge spiCsN) begin
    spiMiso = patBit(riseCnt);
    if (!spiCsN && $time > 0) begin
      if (spiSclk == 1'b0 && riseCnt > 0) tLastFall = $time;
    end
  end
  always @(negedge spiCsN) tCsFall = $time;
  always @(posedge spiCsN) tCsRise = $time;

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  logic [7:0] expFifo [0:7];

  task automatic runCmd(input logic [7:0] op, input int tx, input int rx,
                        input bit useExt, input bit poke);
    logic [7:0] d;
    int total, polls, firstBad;
    logic [7:0] gotByte, wantByte;
    string rtag;
    // counts
    if (useExt) begin
      regWr(5'h1E, 8'd5); regWr(5'h1F, 8'(tx));
      regWr(5'h1E, 8'd6); regWr(5'h1F, 8'(rx));
      regRd(5'h1F, d);
      chk(d == 8'(rx), "R3 extended rx count readback", d, rx);
      regWr(5'h1E, 8'd5); regRd(5'h1F, d);
      chk(d == 8'(tx), "R3 extended tx count readback", d, tx);
      regWr(5'h1E, 8'd9); regRd(5'h1F, d);
      chk(d == 8'h00, "R3 unknown index reads 0", d, 0);
    end else begin
      regWr(5'h01, {4'(rx), 4'(tx)});
      regRd(5'h01, d);
      chk(d == {4'(rx), 4'(tx)}, "R2 packed counts readback", d, {4'(rx), 4'(tx)});
    end
    regWr(5'h00, op);
    regRd(5'h00, d);
    chk(d == op, "R1 opcode readback", d, op);
    regWr(5'h02, 8'h10);
    regRd(5'h0D, d);
    chk(d == 8'h00, "R6 pointer cleared", d, 0);
    for (int i = 0; i < tx; i++) begin
      regWr(5'h0C, payload(op, i));
      expFifo[i % 8] = payload(op, i);
    end
    regRd(5'h0D, d);
    chk(d == 8'(tx % 8), "R5 pointer after payload writes", d, tx % 8);
    // run
    riseCnt = 0;
    regWr(5'h02, 8'h01);
    regRd(5'h02, d);
    chk(d[0] == 1'b1, "R4 run bit set while active", d, 1);
    regRd(5'h03, d);
    chk(d[7] == 1'b1, "R4 busy bit set while active", d, 8'h80);
    if (poke) begin
      regWr(5'h00, ~op);
      regWr(5'h01, 8'hFF);
      regWr(5'h0C, 8'hEE);
      regWr(5'h02, 8'h11);
      regRd(5'h0C, d);
    end
    polls = 0;
    do begin
      regRd(5'h03, d);
      polls++;
    end while (d[7] && polls < 4000);
    chk(d[7] == 1'b0, "R4 busy clears at end", d, 0);
    regRd(5'h02, d);
    chk(d == 8'h00, "R4 run bit clears at end", d, 0);
    // frame shape
    total = (tx == 0) ? ((rx == 0) ? 1 : rx) : 1 + tx + rx;
    chk(riseCnt == 8 * total, "R7 rising edges per frame", riseCnt, 8 * total);
    chk((tFirstRise - tCsFall) == (DIV + HALF) * 10, "R7 lead time",
        int'((tFirstRise - tCsFall) / 10), DIV + HALF);
    chk((tCsRise - tLastFall) == DIV * 10, "R7 trail time",
        int'((tCsRise - tLastFall) / 10), DIV);
    // MOSI content
    firstBad = -1;
    for (int b = 0; b < total && b < 128; b++) begin
      for (int k = 0; k < 8; k++) gotByte[7 - k] = mosiBits[b * 8 + k];
      if (b == 0) wantByte = op;
      else if (b <= tx) wantByte = payload(op, b - 1);
      else wantByte = 8'h00;
      if (gotByte !== wantByte && firstBad < 0) begin
        firstBad = b;
        chk(1'b0, (b == 0) ? "R1 command byte on line" : "R8 serial byte content",
            gotByte, wantByte);
      end
    end
    if (firstBad < 0) chk(1'b1, "R8 serial bytes", 0, 0);
    // model of captured bytes
    for (int k = 0; k < rx; k++) begin
      expFifo[(tx + k) % 8] = pat((tx == 0) ? k : tx + 1 + k);
    end
    if (poke) begin
      regRd(5'h00, d);
      chk(d == op, "R10 opcode write ignored while busy", d, op);
      regRd(5'h01, d);
      chk(d == {4'(rx), 4'(tx)}, "R10 count write ignored while busy", d, {4'(rx), 4'(tx)});
      regRd(5'h0D, d);
      chk(d == 8'(tx % 8), "R10 pointer untouched while busy", d, tx % 8);
    end
    rtag = (tx == 0) ? "R9 dummy-first receive layout" :
           ((tx + rx > 8) ? "R11 wrapped FIFO contents" : "R8 FIFO payload then receive");
    regWr(5'h02, 8'h10);
    for (int e = 0; e < 8; e++) begin
      regRd(5'h0C, d);
      chk(d == expFifo[e], rtag, d, expFifo[e]);
    end
    regRd(5'h0D, d);
    chk(d == 8'h00, "R5 pointer wraps after eight reads", d, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] d;
    for (int e = 0; e < 8; e++) expFifo[e] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk(spiCsN == 1'b1 && spiSclk == 1'b0, "R7 idle pins after reset",
        {spiCsN, spiSclk}, 2'b10);
    regRd(5'h00, d); chk(d == 8'h00, "R1 opcode reset value", d, 0);
    regRd(5'h01, d); chk(d == 8'h00, "R2 counts reset value", d, 0);
    regRd(5'h03, d); chk(d == 8'h00, "R4 idle status after reset", d, 0);
    regRd(5'h0D, d); chk(d == 8'h00, "R5 pointer reset value", d, 0);

    // sweep of legacy packed counts
    for (int t = 0; t <= 4; t++) begin
      for (int r = 0; r <= 5; r++) begin
        runCmd(8'(8'h03 + t * 16 + r), t, r, 1'b0, 1'b0);
      end
    end
    // extended counts, including wrap cases
    runCmd(8'h0B, 3, 9, 1'b1, 1'b0);
    runCmd(8'h9F, 0, 10, 1'b1, 1'b0);
    runCmd(8'h02, 6, 2, 1'b1, 1'b0);
    runCmd(8'hAB, 8, 1, 1'b1, 1'b0);
    // writes during a running command
    runCmd(8'h05, 2, 3, 1'b0, 1'b1);
    runCmd(8'h35, 0, 2, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule